// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and a calendar in binary-coded decimal registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A free-running tick input is divided by a parameterised prescaler, and every completed second advances the time by one second. The carry runs through minutes, hours, the day of week, the date and the month, and on into the year. The date carry knows the lengths of the months and the leap-year rule. A century flag in the month register flips whenever the year wraps.

A host reads and writes every register through a single-cycle port. The write strobe, address and write data are sampled on the clock edge. Read data is a combinational function of the address. The hours register carries its own format bit, so software can choose a 12-hour clock with an AM/PM bit or a 24-hour clock. Four alarm registers, each with a mask bit, are compared against the new time after every step. A match sets a sticky alarm flag. A separate one-cycle strobe marks every minute boundary for neighbouring logic.

Top module: `rtc_calendar`

## Requirements
- R1: A second step happens on every TICKS_PER_SEC-th tick. Seconds count BCD 00 to 59, and the step from 59 to 00 advances the minutes. Minutes count 00 to 59, and the step from 59 to 00 advances the hours. Seconds and minutes hold in every cycle with no step and no host write to them.
- R2: With hours bit 6 = 0 (24-hour), bits 5:0 hold BCD 00 to 23, with bit 5 the tens bit for 20 to 23. Stepping from 23 to 00 advances the day.
- R3: With hours bit 6 = 1 (12-hour), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The sequence is 12, 01, ..., 11. The step from 11 to 12 inverts PM, and the day advances only on 11 PM to 12 AM.
- R4: The day of week (bits 2:0 at address 3) counts 1 to 7 and returns to 1 on each day advance.
- R5: The date counts up to the month's last day, then returns to 01 and advances the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is a multiple of 4 (including 00), and 28 otherwise. All other months have 31. Month 12 wraps to 01 and advances the year.
- R6: A year step from 99 to 00 inverts the century flag in bit 7 of the month register. Other year steps leave the century flag unchanged.
- R7: The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 to 10 alarm seconds/minutes/hours/day, 11 status. Bits that have no function read 0 whatever was written. These are: bit 7 of addresses 0 to 2, bits 7:3 of address 3, bits 7:6 of address 4, bits 6:5 of address 5, bits 6:3 of address 10, and bits 7:1 of address 11.
- R8: A host write to seconds restarts the tick prescaler. A host write to any time register (addresses 0 to 6) cancels a second step that falls in the same cycle; the written value is kept.
- R9: Bit 7 of each alarm register is a mask. A field with its mask set is ignored in the compare. The other fields are compared with the new time after each step: bits 6:0 for seconds, minutes and hours, and bits 2:0 for the day. The flag is set when all unmasked fields match.
- R10: The alarm flag (status bit 0, also the alarm_flag pin) stays set until the host writes status with bit 0 = 0. Writing 1 has no effect, and an alarm in the same cycle wins over a clear.
- R11: minute_strobe is high for exactly the one cycle after a step that takes seconds from 59 to 00.
- R12: After reset the time is 00:00:00 in 24-hour format, day 1, date 01, month 01, year 00, century 0. All alarm registers are 00 and the alarm flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick, one cycle wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| alarm_flag | output | 1 | Sticky alarm flag |
| minute_strobe | output | 1 | One-cycle pulse on each minute boundary |

## Verification
The bench drives the clock across midnight on the last day of the year in 1999 fashion, across February in leap and common years, across a 30-day month, and around the 11-to-12 and 12-to-1 hour steps in both hour formats. A design with a wrong carry chain would show the wrong date, an unflipped century bit, or a PM bit that toggles on the wrong step. Alarm cases cover single-field and full compares, including a day-of-week mismatch, so that ignored masks or a missing field would set the flag too early or never. It also times host writes against the prescaler phase: a design that lets a tick win over a write, or forgets to restart the phase, shifts the seconds by one step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW       = 4;
  localparam int ALARM_FIELDS = 4;

  localparam logic [REG_AW-1:0] A_SEC    = 4'd0;
  localparam logic [REG_AW-1:0] A_MIN    = 4'd1;
  localparam logic [REG_AW-1:0] A_HOUR   = 4'd2;
  localparam logic [REG_AW-1:0] A_WDAY   = 4'd3;
  localparam logic [REG_AW-1:0] A_DATE   = 4'd4;
  localparam logic [REG_AW-1:0] A_MON    = 4'd5;
  localparam logic [REG_AW-1:0] A_YEAR   = 4'd6;
  localparam logic [REG_AW-1:0] A_ALSEC  = 4'd7;
  localparam logic [REG_AW-1:0] A_ALMIN  = 4'd8;
  localparam logic [REG_AW-1:0] A_ALHOUR = 4'd9;
  localparam logic [REG_AW-1:0] A_ALDAY  = 4'd10;
  localparam logic [REG_AW-1:0] A_STAT   = 4'd11;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;   // [6] 12h select, [5] PM / tens-20, [4:0] digits
    logic [2:0] wday;
    logic [5:0] date;
    logic       cent;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  // two-digit BCD increment without range check
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD year divisible by four: tens parity decides which units qualify
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic phase_clr,
  output logic sec_pulse
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse = tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (phase_clr) cnt_q <= '0;
    else if (tick)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt,
  output logic      sec_wrap
);
  logic c_min, c_day, c_mon, c_year, pm;

  always_comb begin
    nxt      = cur;
    pm       = cur.hour[5];
    sec_wrap = (cur.sec == 7'h59);
    c_min    = sec_wrap && (cur.min == 7'h59);
    c_day    = 1'b0;

    nxt.sec = sec_wrap ? 7'h00 : 7'(bcd_inc({1'b0, cur.sec}));
    if (sec_wrap)
      nxt.min = (cur.min == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, cur.min}));

    if (c_min) begin
      if (cur.hour[6]) begin
        if (cur.hour[4:0] == 5'h12) begin
          nxt.hour = {1'b1, pm, 5'h01};
        end else if (cur.hour[4:0] == 5'h11) begin
          nxt.hour = {1'b1, ~pm, 5'h12};
          c_day    = pm;
        end else begin
          nxt.hour = {1'b1, pm, 5'(bcd_inc({3'b0, cur.hour[4:0]}))};
        end
      end else begin
        if (cur.hour[5:0] == 6'h23) begin
          nxt.hour = 7'h00;
          c_day    = 1'b1;
        end else begin
          nxt.hour = {1'b0, 6'(bcd_inc({2'b0, cur.hour[5:0]}))};
        end
      end
    end

    c_mon  = c_day && (cur.date == month_last(cur.mon, cur.year));
    c_year = c_mon && (cur.mon == 5'h12);

    if (c_day) begin
      nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
      nxt.date = c_mon ? 6'h01 : 6'(bcd_inc({2'b0, cur.date}));
    end
    if (c_mon)
      nxt.mon = c_year ? 5'h01 : 5'(bcd_inc({3'b0, cur.mon}));
    if (c_year) begin
      if (cur.year == 8'h99) begin
        nxt.year = 8'h00;
        nxt.cent = ~cur.cent;
      end else begin
        nxt.year = bcd_inc(cur.year);
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int FIELDS = 4
) (
  input  logic [FIELDS-1:0][7:0] alarm_regs,
  input  logic [FIELDS-1:0][6:0] now_fields,
  output logic                   hit
);
  logic [FIELDS-1:0] field_ok;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_field
    assign field_ok[gi] = alarm_regs[gi][7] || (alarm_regs[gi][6:0] == now_fields[gi]);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              alarm_flag,
  output logic              minute_strobe
);
  rtc_time_t cur, nxt;
  logic [ALARM_FIELDS-1:0][7:0] al_q;
  logic [ALARM_FIELDS-1:0][6:0] al_now;
  logic taf_q, strobe_q, sec_pulse, sec_wrap, alarm_hit;
  logic time_wr, sec_wr, taf_clr, step_en;

  assign time_wr = bus_wr && (bus_addr <= A_YEAR);
  assign sec_wr  = bus_wr && (bus_addr == A_SEC);
  assign taf_clr = bus_wr && (bus_addr == A_STAT) && !bus_wdata[0];
  assign step_en = sec_pulse && !time_wr;

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase_clr(sec_wr), .sec_pulse(sec_pulse)
  );

  rtc_advance u_adv (.cur(cur), .nxt(nxt), .sec_wrap(sec_wrap));

  assign al_now = {{4'b0, nxt.wday}, nxt.hour, nxt.min, nxt.sec};

  rtc_alarm_match #(.FIELDS(ALARM_FIELDS)) u_alm (
    .alarm_regs(al_q), .now_fields(al_now), .hit(alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '{sec: 7'h00, min: 7'h00, hour: 7'h00, wday: 3'd1, date: 6'h01,
                    cent: 1'b0, mon: 5'h01, year: 8'h00};
      al_q     <= '0;
      taf_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= step_en && sec_wrap;
      if (step_en) cur <= nxt;
      if (bus_wr) begin
        case (bus_addr)
          A_SEC:    cur.sec  <= bus_wdata[6:0];
          A_MIN:    cur.min  <= bus_wdata[6:0];
          A_HOUR:   cur.hour <= bus_wdata[6:0];
          A_WDAY:   cur.wday <= bus_wdata[2:0];
          A_DATE:   cur.date <= bus_wdata[5:0];
          A_MON:    begin cur.cent <= bus_wdata[7]; cur.mon <= bus_wdata[4:0]; end
          A_YEAR:   cur.year <= bus_wdata;
          A_ALSEC:  al_q[0]  <= bus_wdata;
          A_ALMIN:  al_q[1]  <= bus_wdata;
          A_ALHOUR: al_q[2]  <= bus_wdata;
          A_ALDAY:  al_q[3]  <= {bus_wdata[7], 4'b0, bus_wdata[2:0]};
          default:  ;
        endcase
      end
      if (step_en && alarm_hit) taf_q <= 1'b1;
      else if (taf_clr)         taf_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SEC:    bus_rdata = {1'b0, cur.sec};
      A_MIN:    bus_rdata = {1'b0, cur.min};
      A_HOUR:   bus_rdata = {1'b0, cur.hour};
      A_WDAY:   bus_rdata = {5'b0, cur.wday};
      A_DATE:   bus_rdata = {2'b0, cur.date};
      A_MON:    bus_rdata = {cur.cent, 2'b0, cur.mon};
      A_YEAR:   bus_rdata = cur.year;
      A_ALSEC:  bus_rdata = al_q[0];
      A_ALMIN:  bus_rdata = al_q[1];
      A_ALHOUR: bus_rdata = al_q[2];
      A_ALDAY:  bus_rdata = al_q[3];
      A_STAT:   bus_rdata = {7'b0, taf_q};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign alarm_flag    = taf_q;
  assign minute_strobe = strobe_q;
endmodule

// File: rtl/rtc_calendar_sva.sv
module rtc_calendar_sva
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic              wdata_lsb,
  input logic              rdata_msb,
  input logic              alarm_flag,
  input logic              minute_strobe,
  input logic              step_en,
  input logic [6:0]        sec_now
);
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !(bus_wr && bus_addr == A_SEC)) |=> $stable(sec_now)); // R1

  AST_SEC_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SEC) |-> !rdata_msb); // R7

  AST_TAF_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !step_en) |=> !alarm_flag); // R9

  AST_TAF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !(bus_wr && bus_addr == A_STAT && !wdata_lsb)) |=> alarm_flag); // R10

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    minute_strobe |-> (sec_now == 7'h00)); // R11

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    minute_strobe |=> !minute_strobe); // R11
endmodule

bind rtc_calendar rtc_calendar_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lsb(bus_wdata[0]), .rdata_msb(bus_rdata[7]), .alarm_flag(alarm_flag),
  .minute_strobe(minute_strobe), .step_en(step_en), .sec_now(cur.sec)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/100ps
module rtc_calendar_tb;
  localparam int TPS = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic alarm_flag, minute_strobe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_flag(alarm_flag),
    .minute_strobe(minute_strobe)
  );

  // behavioural reference model, plain integers
  int m_sec, m_min, m_hr, m_mode, m_wday, m_date, m_mon, m_yr, m_cent, m_phase, m_taf, m_strobe;
  logic [7:0] m_al [4];

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int n);
    return 8'(((n / 10) << 4) + (n % 10));
  endfunction

  function automatic int dim();
    if (m_mon == 2) return (m_yr % 4 == 0) ? 29 : 28;
    if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] model_reg(input int a);
    logic [7:0] b;
    int h;
    case (a)
      0: return i2b(m_sec);
      1: return i2b(m_min);
      2: begin
        if (m_mode != 0) begin
          h = m_hr % 12;
          if (h == 0) h = 12;
          b = i2b(h);
          return {2'b01, (m_hr >= 12), b[4:0]};
        end
        return i2b(m_hr);
      end
      3: return 8'(m_wday);
      4: return i2b(m_date);
      5: begin b = i2b(m_mon); return {m_cent[0], 2'b00, b[4:0]}; end
      6: return i2b(m_yr);
      7, 8, 9, 10: return m_al[a-7];
      11: return {7'b0, m_taf[0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R1";
      2: return "R2";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7, 8, 9, 10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_mode = 0; m_wday = 1; m_date = 1; m_mon = 1;
    m_yr = 0; m_cent = 0; m_phase = 0; m_taf = 0; m_strobe = 0;
    for (int i = 0; i < 4; i++) m_al[i] = 8'h00;
  endtask

  task automatic model_advance();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_wday = (m_wday == 7) ? 1 : m_wday + 1;
          m_date++;
          if (m_date > dim()) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr++;
              if (m_yr == 100) begin m_yr = 0; m_cent = 1 - m_cent; end
            end
          end
        end
      end
    end
  endtask

  function automatic bit model_alarm();
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r = model_reg(i);
      if (!m_al[i][7] && (m_al[i][6:0] != r[6:0])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    int h;
    case (a)
      0: m_sec = b2i(d & 8'h7F);
      1: m_min = b2i(d & 8'h7F);
      2: begin
        m_mode = int'(d[6]);
        if (d[6]) begin
          h = b2i({3'b0, d[4:0]});
          m_hr = (h % 12) + (d[5] ? 12 : 0);
        end else m_hr = b2i({2'b0, d[5:0]});
      end
      3: m_wday = int'(d[2:0]);
      4: m_date = b2i({2'b0, d[5:0]});
      5: begin m_cent = int'(d[7]); m_mon = b2i({3'b0, d[4:0]}); end
      6: m_yr = b2i(d);
      7, 8, 9: m_al[a-7] = d;
      10: m_al[3] = {d[7], 4'b0, d[2:0]};
      11: if (!d[0]) m_taf = 0;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit stp, twr, fire;
    if (!rst_n) model_reset();
    else begin
      stp = tick && (m_phase == TPS - 1);
      if (bus_wr && bus_addr == 4'd0) m_phase = 0;
      else if (tick) m_phase = (m_phase + 1) % TPS;
      twr = bus_wr && (bus_addr <= 4'd6);
      m_strobe = 0;
      fire = 0;
      if (stp && !twr) begin
        model_advance();
        m_strobe = (m_sec == 0);
        fire = model_alarm();
      end
      if (bus_wr) model_write(int'(bus_addr), bus_wdata);
      if (fire) m_taf = 1;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sweep();
    bus_wr = 1'b0; tick = 1'b0;
    for (int a = 0; a < 12; a++) begin
      bus_addr = 4'(a);
      #0.5;
      check(bus_rdata, model_reg(a), tag_of(a));
    end
    check({7'b0, alarm_flag}, 8'(m_taf), "R10 flag pin");
    check({7'b0, minute_strobe}, 8'(m_strobe), "R11 strobe");
  endtask

  task automatic cyc(input bit t, input bit w, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sweep();
    tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'd0, 8'h00);
  endtask

  task automatic peek(input logic [3:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, 1'b0, a, 8'h00);
    #0.5;
    check(bus_rdata, exp, tag);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    peek(4'd0, 8'h00, "R12 seconds");
    peek(4'd2, 8'h00, "R12 hours");
    peek(4'd3, 8'h01, "R12 weekday");
    peek(4'd4, 8'h01, "R12 date");
    peek(4'd5, 8'h01, "R12 month");
    peek(4'd7, 8'h00, "R12 alarm seconds");
    peek(4'd11, 8'h00, "R12 status");

    // year end, century flip
    wr(4'd3, 8'h07); wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    run(TPS);
    cyc(1'b0, 1'b0, 4'd0, 8'h00);
    #0.5;
    check({7'b0, minute_strobe}, 8'h01, "R11 strobe after 59");
    peek(4'd5, 8'h81, "R6 century toggled");
    peek(4'd6, 8'h00, "R6 year wrapped");
    peek(4'd3, 8'h01, "R4 weekday wrap");
    peek(4'd2, 8'h00, "R2 23 to 00");
    peek(4'd1, 8'h00, "R1 minutes wrap");

    // February, leap and common years, 30-day month
    wr(4'd5, 8'h02); wr(4'd6, 8'h04); wr(4'd4, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); run(TPS);
    peek(4'd4, 8'h29, "R5 leap Feb 29");
    set_time(8'h23, 8'h59, 8'h59); run(TPS);
    peek(4'd4, 8'h01, "R5 leap Mar 1");
    peek(4'd5, 8'h03, "R5 month after Feb");
    wr(4'd5, 8'h02); wr(4'd6, 8'h03); wr(4'd4, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); run(TPS);
    peek(4'd4, 8'h01, "R5 common Feb 28 to Mar 1");
    wr(4'd5, 8'h02); wr(4'd6, 8'h00); wr(4'd4, 8'h28);
    set_time(8'h23, 8'h59, 8'h59); run(TPS);
    peek(4'd4, 8'h29, "R5 year 00 leap");
    wr(4'd5, 8'h04); wr(4'd4, 8'h30);
    set_time(8'h23, 8'h59, 8'h59); run(TPS);
    peek(4'd5, 8'h05, "R5 April has 30 days");

    // hour formats
    set_time(8'h51, 8'h59, 8'h59); run(TPS);
    peek(4'd2, 8'h72, "R3 11 AM to 12 PM");
    set_time(8'h72, 8'h59, 8'h59); run(TPS);
    peek(4'd2, 8'h61, "R3 12 PM to 1 PM");
    wr(4'd4, 8'h15);
    set_time(8'h71, 8'h59, 8'h59); run(TPS);
    peek(4'd2, 8'h52, "R3 11 PM to 12 AM");
    peek(4'd4, 8'h16, "R3 day advance at midnight");
    set_time(8'h19, 8'h59, 8'h59); run(TPS);
    peek(4'd2, 8'h20, "R2 19 to 20");

    // alarm on seconds only
    wr(4'd11, 8'h00); wr(4'd8, 8'h80); wr(4'd9, 8'h80); wr(4'd10, 8'h80); wr(4'd7, 8'h05);
    set_time(8'h20, 8'h10, 8'h03); run(TPS);
    peek(4'd11, 8'h00, "R9 no match yet");
    run(TPS);
    peek(4'd11, 8'h01, "R9 masked alarm fires");
    wr(4'd11, 8'hFF);
    peek(4'd11, 8'h01, "R10 writing one keeps flag");
    wr(4'd11, 8'h00);
    peek(4'd11, 8'h00, "R10 writing zero clears");

    // full compare, weekday decides
    wr(4'd7, 8'h10); wr(4'd8, 8'h20); wr(4'd9, 8'h08); wr(4'd10, 8'h03); wr(4'd3, 8'h04);
    set_time(8'h08, 8'h20, 8'h09); run(TPS);
    peek(4'd11, 8'h00, "R9 weekday mismatch");
    wr(4'd3, 8'h03);
    set_time(8'h08, 8'h20, 8'h09); run(TPS);
    peek(4'd11, 8'h01, "R9 full match");
    wr(4'd11, 8'h00);

    // prescaler phase and write priority
    wr(4'd0, 8'h30); run(2); wr(4'd0, 8'h30); run(TPS - 1);
    peek(4'd0, 8'h30, "R8 phase restarted");
    run(1);
    peek(4'd0, 8'h31, "R8 step after full period");
    run(TPS - 1);
    cyc(1'b1, 1'b1, 4'd1, 8'h45);
    peek(4'd0, 8'h31, "R8 step dropped on write");
    peek(4'd1, 8'h45, "R8 written minutes kept");
    run(TPS);
    peek(4'd0, 8'h32, "R8 stepping resumes");

    // unused bits
    wr(4'd0, 8'hD9);
    peek(4'd0, 8'h59, "R7 seconds bit 7");
    wr(4'd3, 8'hFB);
    peek(4'd3, 8'h03, "R7 weekday high bits");
    wr(4'd4, 8'hD2);
    peek(4'd4, 8'h12, "R7 date high bits");
    wr(4'd10, 8'hFD);
    peek(4'd10, 8'h85, "R7 alarm day middle bits");
    wr(4'd11, 8'hFE);
    peek(4'd11, 8'h00, "R7 status upper bits");

    repeat (3) cyc(1'b0, 1'b0, 4'd0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule